// File: doc/BRIEF.md
# Device Error Syndrome Logger

This block sits inside one device and keeps a record of the first fault that device sees. When an error event arrives and no record is held, the block stores the syndrome payload, raises its first-error-valid flag and sends a one-cycle error pulse to the central management node. Later events do not overwrite the record. They only set a sticky multiple-error flag, so software can tell that more faults came after the one it is reading.

Software reads the record through a syndrome register. It then releases the record through a separate write-to-clear register, using either one 64-bit access or one 32-bit access to the upper word. Only two bit positions in a clear write have any effect; every other written bit is ignored. If a clear and a new error land in the same cycle, the clear is applied first, and the new error is then logged as a fresh first error.

Top module: `err_synd_logger`

## Requirements
- R1: An error event (`errValid` high at a clock edge) while first-error-valid is clear stores `errSynd`, sets first-error-valid and drives `errSignal` high for exactly the following cycle.
- R2: An error event while first-error-valid is set sets multiple-error, leaves the stored payload unchanged and gives no `errSignal` pulse.
- R3: An error event while both flags are set changes no state and gives no pulse.
- R4: A 64-bit write (`regWide`=1) to offset 0x480 with bit 62 set clears first-error-valid, and with bit 59 set clears multiple-error. All other data bits are ignored.
- R5: A 32-bit write (`regWide`=0) to offset 0x484 acts on the upper word: bit 30 clears first-error-valid and bit 27 clears multiple-error. Both 0x48000000 and 0xFFFFFFFF clear both flags.
- R6: A 64-bit read at offset 0x400 returns first-error-valid in bit 62, multiple-error in bit 59, the stored payload in bits [SYND_W-1:0] and zero elsewhere. A 32-bit read at 0x404 returns bits [63:32] of that word in the low 32 bits. Read data is combinational, and any other address or width reads zero.
- R7: A write with any other offset/width pairing (for example a 32-bit write to 0x480, or a 64-bit write to 0x484) has no effect.
- R8: When a clear and an error event occur in the same cycle, the clear takes effect first. If first-error-valid ends up clear, the new payload is stored as a fresh first error and `errSignal` pulses.
- R9: After reset both flags and the payload are zero and `errSignal` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| errValid | input | 1 | Error event strobe |
| errSynd | input | SYND_W | Syndrome payload of the event |
| errSignal | output | 1 | One-cycle error pulse to the management node |
| regWr | input | 1 | Register write strobe |
| regWide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| regAddr | input | ADDR_W | Register byte offset |
| regWdata | input | 64 | Write data (a 32-bit access uses bits [31:0]) |
| regRdata | output | 64 | Read data for the addressed register |

## Verification
Flags, payload and `errSignal` all change at the clock edge that samples the event or the write. The pulse is therefore high during the cycle after that edge, and the read word shows the new state in that same cycle with no further delay. The bench drives one stimulus per cycle at the falling edge. It updates its behavioural model at the rising edge and compares `errSignal` shortly afterwards. It then sets up an idle read of 0x400, or of 0x404 in 32-bit mode, and compares the combinational read data before the next edge.

// File: rtl/err_synd_pkg.sv
package err_synd_pkg;
  // Flag positions in the 64-bit syndrome/clear word
  localparam int FV_BIT = 62;
  localparam int ME_BIT = 59;
  localparam int WORD_W = 64;
  localparam int HALF_W = 32;
  localparam int FV_BIT_HI = FV_BIT - HALF_W;
  localparam int ME_BIT_HI = ME_BIT - HALF_W;

  // Control-to-datapath strobes and flag state
  typedef struct packed {
    logic capture;
    logic firstValid;
    logic multErr;
  } strobes_t;
endpackage

// File: rtl/err_synd_ctrl.sv
module err_synd_ctrl
  import err_synd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CLR_OFS = 12'h480
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              errValid,
  input  logic              regWr,
  input  logic              regWide,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output logic              errSignal,
  output strobes_t          ctl
);
  localparam logic [ADDR_W-1:0] CLR_OFS_HI = CLR_OFS + ADDR_W'(4);

  logic firstValid, multErr;
  logic hitWide, hitHalf, clrFirst, clrMult;
  logic fvAfter, meAfter, capture, setMult;
  logic unusedWdata;

  assign hitWide  = regWr &&  regWide && (regAddr == CLR_OFS);
  assign hitHalf  = regWr && !regWide && (regAddr == CLR_OFS_HI);
  assign clrFirst = (hitWide && regWdata[FV_BIT]) || (hitHalf && regWdata[FV_BIT_HI]);
  assign clrMult  = (hitWide && regWdata[ME_BIT]) || (hitHalf && regWdata[ME_BIT_HI]);

  // Clear first, then the event sees the post-clear flags
  assign fvAfter = firstValid & ~clrFirst;
  assign meAfter = multErr & ~clrMult;
  assign capture = errValid & ~fvAfter;
  assign setMult = errValid &  fvAfter;

  assign unusedWdata = ^regWdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      firstValid <= 1'b0;
      multErr    <= 1'b0;
      errSignal  <= 1'b0;
    end else begin
      firstValid <= fvAfter | capture;
      multErr    <= meAfter | setMult;
      errSignal  <= capture;
    end
  end

  always_comb begin
    ctl.capture    = capture;
    ctl.firstValid = firstValid;
    ctl.multErr    = multErr;
  end
endmodule

// File: rtl/err_synd_dp.sv
module err_synd_dp
  import err_synd_pkg::*;
#(
  parameter int SYND_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] RD_OFS = 12'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          ctl,
  input  logic [SYND_W-1:0] errSynd,
  input  logic              regWide,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [SYND_W-1:0] syndQ,
  output logic [WORD_W-1:0] regRdata
);
  localparam logic [ADDR_W-1:0] RD_OFS_HI = RD_OFS + ADDR_W'(4);

  logic [WORD_W-1:0] word;

  always_ff @(posedge clk) begin
    if (!rst_n)           syndQ <= '0;
    else if (ctl.capture) syndQ <= errSynd;
  end

  always_comb begin
    word = '0;
    word[SYND_W-1:0] = syndQ;
    word[FV_BIT]     = ctl.firstValid;
    word[ME_BIT]     = ctl.multErr;
  end

  always_comb begin
    regRdata = '0;
    if (regWide && regAddr == RD_OFS)
      regRdata = word;
    else if (!regWide && regAddr == RD_OFS_HI)
      regRdata[HALF_W-1:0] = word[WORD_W-1:HALF_W];
  end
endmodule

// File: rtl/err_synd_logger.sv
module err_synd_logger
  import err_synd_pkg::*;
#(
  parameter int SYND_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] RD_OFS  = 12'h400,
  parameter logic [ADDR_W-1:0] CLR_OFS = 12'h480
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              errValid,
  input  logic [SYND_W-1:0] errSynd,
  output logic              errSignal,
  input  logic              regWr,
  input  logic              regWide,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [63:0]       regWdata,
  output logic [63:0]       regRdata
);
  strobes_t          ctl;
  logic              firstValid, multErr;
  logic [SYND_W-1:0] syndQ;

  err_synd_ctrl #(.ADDR_W(ADDR_W), .CLR_OFS(CLR_OFS)) ctrlI (
    .clk(clk), .rst_n(rst_n), .errValid(errValid), .regWr(regWr),
    .regWide(regWide), .regAddr(regAddr), .regWdata(regWdata),
    .errSignal(errSignal), .ctl(ctl)
  );

  err_synd_dp #(.SYND_W(SYND_W), .ADDR_W(ADDR_W), .RD_OFS(RD_OFS)) dpI (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .errSynd(errSynd),
    .regWide(regWide), .regAddr(regAddr), .syndQ(syndQ), .regRdata(regRdata)
  );

  assign firstValid = ctl.firstValid;
  assign multErr    = ctl.multErr;
endmodule

// File: rtl/err_synd_chk.sv
module err_synd_chk #(
  parameter int SYND_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] RD_OFS = 12'h400
) (
  input logic              clk,
  input logic              rst_n,
  input logic              errValid,
  input logic              errSignal,
  input logic              firstValid,
  input logic              multErr,
  input logic [SYND_W-1:0] syndQ,
  input logic              regWide,
  input logic [ADDR_W-1:0] regAddr,
  input logic [63:0]       regRdata
);
  AST_PULSE_MEANS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    errSignal |-> firstValid); // R1

  AST_PULSE_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    errSignal |-> $past(errValid)); // R8

  AST_MULT_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(multErr) |-> (firstValid && $past(firstValid) && $past(errValid))); // R2

  AST_SYND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (firstValid && $past(firstValid) && !errSignal) |-> $stable(syndQ)); // R3

  AST_READ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (regWide && regAddr == RD_OFS) |-> (regRdata[62] == firstValid && regRdata[59] == multErr)); // R6
endmodule

bind err_synd_logger err_synd_chk #(.SYND_W(SYND_W), .ADDR_W(ADDR_W), .RD_OFS(RD_OFS)) chkI (
  .clk(clk), .rst_n(rst_n), .errValid(errValid), .errSignal(errSignal),
  .firstValid(firstValid), .multErr(multErr), .syndQ(syndQ),
  .regWide(regWide), .regAddr(regAddr), .regRdata(regRdata)
);

// File: tb/err_synd_logger_tb_top.sv
`timescale 1ns/1ps
module err_synd_logger_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        errValid = 1'b0;
  logic [31:0] errSynd = '0;
  logic        errSignal;
  logic        regWr = 1'b0;
  logic        regWide = 1'b1;
  logic [11:0] regAddr = 12'h400;
  logic [63:0] regWdata = '0;
  logic [63:0] regRdata;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // Reference state
  bit          mFv, mMe, mPulse;
  logic [31:0] mSyn;

  always #4 clk = ~clk;

  err_synd_logger dut_i (
    .clk(clk), .rst_n(rst_n), .errValid(errValid), .errSynd(errSynd),
    .errSignal(errSignal), .regWr(regWr), .regWide(regWide),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata)
  );

  function automatic logic [63:0] expWord();
    logic [63:0] w = '0;
    w[31:0] = mSyn;
    w[62] = mFv;
    w[59] = mMe;
    return w;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idleRead(input string tag, input bit half);
    regWr = 1'b0; errValid = 1'b0;
    regWide = !half;
    regAddr = half ? 12'h404 : 12'h400;
    #1;
    if (half) check({tag, " rd32"}, regRdata, {32'h0, expWord() >> 32});
    else      check({tag, " rd64"}, regRdata, expWord());
  endtask

  task automatic step(input bit ev, input logic [31:0] sy, input bit wr, input bit wide,
                      input logic [11:0] addr, input logic [63:0] wd, input string tag);
    bit cF, cM, fa, ma;
    errValid = ev; errSynd = sy; regWr = wr; regWide = wide; regAddr = addr; regWdata = wd;
    @(posedge clk);
    cF = wr && ((wide && addr == 12'h480 && wd[62]) || (!wide && addr == 12'h484 && wd[30]));
    cM = wr && ((wide && addr == 12'h480 && wd[59]) || (!wide && addr == 12'h484 && wd[27]));
    fa = mFv && !cF;
    ma = mMe && !cM;
    mPulse = ev && !fa;
    if (mPulse) mSyn = sy;
    mMe = ma || (ev && fa);
    mFv = fa || ev;
    #2;
    check({tag, " pulse"}, {63'h0, errSignal}, {63'h0, mPulse});
    idleRead(tag, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    mFv = 0; mMe = 0; mPulse = 0; mSyn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 reset pulse", {63'h0, errSignal}, 64'h0);
    check("R9 reset word", regRdata, 64'h0);
    @(negedge clk);

    step(1, 32'hA1A1_0001, 0, 1, 12'h000, 0, "R1 first error");
    step(1, 32'hB2B2_0002, 0, 1, 12'h000, 0, "R2 second error");
    step(1, 32'hC3C3_0003, 0, 1, 12'h000, 0, "R3 third error");
    idleRead("R6 upper word", 1'b1);
    @(negedge clk);
    step(0, 0, 1, 1, 12'h480, ~((64'h1 << 62) | (64'h1 << 59)), "R4 other bits ignored");
    step(0, 0, 1, 1, 12'h480, 64'h1 << 59, "R4 clear mult only");
    step(0, 0, 1, 1, 12'h480, 64'h4800_0000_0000_0000, "R4 clear both");
    step(1, 32'hD4D4_0004, 0, 1, 12'h000, 0, "R1 capture again");
    step(1, 32'hDEAD_0005, 0, 1, 12'h000, 0, "R2 mult again");
    step(0, 0, 1, 0, 12'h480, 64'hFFFF_FFFF, "R7 32-bit at low word");
    step(0, 0, 1, 1, 12'h484, '1, "R7 64-bit at upper word");
    step(0, 0, 1, 1, 12'h488, '1, "R7 other offset");
    step(0, 0, 1, 0, 12'h484, 64'hFFFF_FFFF, "R5 32-bit all ones");
    step(1, 32'hE5E5_0006, 0, 1, 12'h000, 0, "R1 capture E");
    step(1, 32'hF6F6_0007, 0, 1, 12'h000, 0, "R2 mult F");
    idleRead("R6 upper word flags", 1'b1);
    @(negedge clk);
    step(0, 0, 1, 0, 12'h484, 64'h4800_0000, "R5 32-bit pattern");
    step(1, 32'h1111_0008, 0, 1, 12'h000, 0, "R1 capture G");
    step(1, 32'h2222_0009, 1, 1, 12'h480, '1, "R8 clear with error");
    step(1, 32'h3333_000A, 1, 1, 12'h480, 64'h1 << 59, "R8 mult clear with error");
    step(1, 32'h4444_000B, 1, 0, 12'h484, 64'h4000_0000, "R8 first clear with error");

    for (int i = 0; i < 400; i++) begin
      logic [63:0] wd;
      int a;
      wd = '0;
      a = $urandom_range(0, 3);
      if ($urandom_range(0, 1) == 1) wd[62] = 1'b1;
      if ($urandom_range(0, 1) == 1) wd[59] = 1'b1;
      if ($urandom_range(0, 1) == 1) wd[30] = 1'b1;
      if ($urandom_range(0, 1) == 1) wd[27] = 1'b1;
      step($urandom_range(0, 2) == 0, $urandom, $urandom_range(0, 3) == 0,
           $urandom_range(0, 1) == 1, (a == 0) ? 12'h480 : (a == 1) ? 12'h484 : 12'h400,
           wd, "R8 mixed traffic");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule